// File: doc/BRIEF.md
# Processor-Bus to PCI Write Bridge

This block is the write-path controller between a split-transaction processor bus, where it acts as a slave, and a PCI master port. Each request is sorted by direction, transfer shape and address space. Single writes of one to four bytes to memory or I/O space are posted into a small buffer and finish on the processor bus at once. The buffer then drains to PCI on its own. Single writes to configuration or special-cycle space are not posted. The processor bus is held with a wait signal until PCI has settled the transfer.

The PCI side is a plain handshake. The block raises `pciReq` with an address, data, byte enables and space. A response strobe then reports accept, retry, disconnect, master abort or target abort. A posted write that is retried or disconnected is tried again from the buffer, and the processor bus never sees it. A held write that is retried makes the processor bus rearbitrate. A held write that is aborted finishes with a master error. An abort on a posted write can no longer reach its processor cycle, so it sets a sticky error flag. Reads, bursts and line transfers get no answer at all.

Top module: `pci_write_bridge`

## Requirements
- R1: A read, a burst or a line transfer, in any space, draws no wait, completion, rearbitrate or error on the processor bus, and it starts no PCI request.
- R2: A single write to memory (space 0) or I/O (space 1) with a free buffer entry asserts `slvComplete` in the same cycle it is presented, and `pciReq` rises on the next cycle.
- R3: A PCI accept (response 0) of a posted write removes it from the buffer, and `pciReq` falls when no other work is pending.
- R4: A retry (response 1) or disconnect (response 2) of a posted write drops `pciReq` for exactly one cycle. The request then rises again for the same entry, and the processor bus sees nothing.
- R5: A single write to configuration (space 2) or special-cycle (space 3) space raises `slvWait` and is held. It goes to PCI only after every earlier posted write has left the buffer.
- R6: A retry of a held write pulses `slvRearb` without `slvComplete`, and the PCI request is dropped.
- R7: An accept or a disconnect of a held write pulses `slvComplete` in the same cycle as the PCI response.
- R8: A master abort (response 3) or target abort (response 4) of a held write pulses `slvComplete` together with `slvMErr`.
- R9: A memory or I/O write that arrives while both buffer entries are full is held with `slvWait`. It completes in the cycle in which PCI accepts the buffer head.
- R10: Posted writes reach PCI in the order they arrived.
- R11: A master abort or target abort of a posted write drops that entry and sets `errFlag`, which stays set until reset.
- R12: During reset and right after it, every processor-bus response, `pciReq` and `errFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present, held until answered |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Burst transfer |
| reqLine | input | 1 | Line-sized transfer |
| reqSpace | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 special cycle |
| reqAddr | input | 32 | Request address |
| reqData | input | 32 | Write data |
| reqBe | input | 4 | Byte enables |
| slvWait | output | 1 | Slave wait, processor cycle held |
| slvComplete | output | 1 | Slave completion pulse |
| slvRearb | output | 1 | Rearbitrate pulse |
| slvMErr | output | 1 | Master error, given with completion |
| pciReq | output | 1 | PCI transaction request |
| pciAddr | output | 32 | PCI address |
| pciData | output | 32 | PCI write data |
| pciBe | output | 4 | PCI byte enables |
| pciSpace | output | 2 | PCI space, same coding as reqSpace |
| pciRespValid | input | 1 | PCI response strobe |
| pciResp | input | 3 | 0 accept, 1 retry, 2 disconnect, 3 master abort, 4 target abort |
| errFlag | output | 1 | Sticky error from an aborted posted write |

## Verification
A new memory write can meet a full buffer in the same cycle in which PCI accepts the buffer head. The pop that frees an entry and the push of the waiting write then fall together. The bench fills both entries, presents a third write, and checks that `slvWait` is high and `slvComplete` low. It then answers accept while the third write is still presented, and expects `slvComplete` in that very cycle with `slvWait` low. The three addresses must then come out on PCI in arrival order.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {SP_MEM, SP_IO, SP_CFG, SP_SPECIAL} space_e;
  typedef enum logic [2:0] {PR_ACCEPT, PR_RETRY, PR_DISCONNECT, PR_MABORT, PR_TABORT} presp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic loadHold;
    logic selHold;
  } dp_ctrl_t;
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath import pwb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctrl_t            ctrl,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [DATA_W-1:0]   inData,
  input  logic [DATA_W/8-1:0] inBe,
  input  logic [1:0]          inSpace,
  output logic                bufFull,
  output logic                bufEmpty,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [DATA_W-1:0]   outData,
  output logic [DATA_W/8-1:0] outBe,
  output logic [1:0]          outSpace
);
  localparam int BE_W  = DATA_W / 8;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slotAddr  [DEPTH];
  logic [DATA_W-1:0] slotData  [DEPTH];
  logic [BE_W-1:0]   slotBe    [DEPTH];
  logic [1:0]        slotSpace [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic [BE_W-1:0]   holdBe;
  logic [1:0]        holdSpace;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign bufFull  = (count == CNT_W'(DEPTH));
  assign bufEmpty = (count == '0);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (ctrl.push && wrPtr == PTR_W'(g)) begin
          slotAddr[g]  <= inAddr;
          slotData[g]  <= inData;
          slotBe[g]    <= inBe;
          slotSpace[g] <= inSpace;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctrl.push) wrPtr <= nextPtr(wrPtr);
      if (ctrl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctrl.push, ctrl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.loadHold) begin
      holdAddr  <= inAddr;
      holdData  <= inData;
      holdBe    <= inBe;
      holdSpace <= inSpace;
    end
  end

  always_comb begin
    if (ctrl.selHold) begin
      outAddr  = holdAddr;
      outData  = holdData;
      outBe    = holdBe;
      outSpace = holdSpace;
    end else begin
      outAddr  = slotAddr[rdPtr];
      outData  = slotData[rdPtr];
      outBe    = slotBe[rdPtr];
      outSpace = slotSpace[rdPtr];
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push && !ctrl.pop) |-> !bufFull);
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |-> !bufEmpty);
endmodule

// File: rtl/pwb_control.sv
module pwb_control import pwb_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqBurst,
  input  logic       reqLine,
  input  logic [1:0] reqSpace,
  input  logic       pciRespValid,
  input  logic [2:0] pciResp,
  input  logic       bufFull,
  input  logic       bufEmpty,
  output logic       slvWait,
  output logic       slvComplete,
  output logic       slvRearb,
  output logic       slvMErr,
  output logic       pciReq,
  output logic       errFlag,
  output dp_ctrl_t   ctrl
);
  typedef enum logic {ST_IDLE, ST_HOLD} state_e;
  state_e state;
  logic   backoff;

  space_e space;
  presp_e resp;
  logic singleWr, postSpace, idle, wantPost, wantHold;
  logic respOk, respRetry, respAbort, headResp, holdResp, holdDone;

  assign space     = space_e'(reqSpace);
  assign resp      = presp_e'(pciResp);
  assign idle      = (state == ST_IDLE);
  assign singleWr  = reqWrite && !reqBurst && !reqLine;
  assign postSpace = (space == SP_MEM) || (space == SP_IO);
  assign wantPost  = reqValid && singleWr && postSpace && idle;
  assign wantHold  = reqValid && singleWr && !postSpace && idle;

  assign respOk    = (resp == PR_ACCEPT) || (resp == PR_DISCONNECT);
  assign respRetry = (resp == PR_RETRY);
  assign respAbort = (resp == PR_MABORT) || (resp == PR_TABORT);

  // posted entries go first; held write only once the buffer is empty
  assign pciReq   = !backoff && (!bufEmpty || state == ST_HOLD);
  assign headResp = pciRespValid && pciReq && !bufEmpty;
  assign holdResp = pciRespValid && pciReq && bufEmpty && (state == ST_HOLD);
  assign holdDone = holdResp && (respOk || respRetry || respAbort);

  always_comb begin
    ctrl          = '0;
    ctrl.pop      = headResp && ((resp == PR_ACCEPT) || respAbort);
    ctrl.push     = wantPost && (!bufFull || ctrl.pop);
    ctrl.loadHold = wantHold;
    ctrl.selHold  = bufEmpty;
  end

  assign slvComplete = ctrl.push || (holdResp && (respOk || respAbort));
  assign slvMErr     = holdResp && respAbort;
  assign slvRearb    = holdResp && respRetry;
  assign slvWait     = (wantPost && !ctrl.push) || wantHold
                       || (state == ST_HOLD && !holdDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      backoff <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (wantHold)      state <= ST_HOLD;
      else if (holdDone) state <= ST_IDLE;
      backoff <= headResp && (respRetry || resp == PR_DISCONNECT);
      if (headResp && respAbort) errFlag <= 1'b1;
    end
  end

  a_r1_no_reply: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && idle && !singleWr) |-> (!slvWait && !slvComplete && !slvRearb));
  a_r4_backoff_gap: assert property (@(posedge clk) disable iff (!rstN)
    (headResp && (respRetry || resp == PR_DISCONNECT)) |=> !pciReq);
  a_r5_hold_waits: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !pciRespValid) |-> slvWait);
  a_r6_rearb_alone: assert property (@(posedge clk) disable iff (!rstN)
    slvRearb |-> !slvComplete);
  a_r8_merr_completes: assert property (@(posedge clk) disable iff (!rstN)
    slvMErr |-> slvComplete);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

// File: rtl/pci_write_bridge.sv
module pci_write_bridge import pwb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqBurst,
  input  logic                reqLine,
  input  logic [1:0]          reqSpace,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                slvWait,
  output logic                slvComplete,
  output logic                slvRearb,
  output logic                slvMErr,
  output logic                pciReq,
  output logic [ADDR_W-1:0]   pciAddr,
  output logic [DATA_W-1:0]   pciData,
  output logic [DATA_W/8-1:0] pciBe,
  output logic [1:0]          pciSpace,
  input  logic                pciRespValid,
  input  logic [2:0]          pciResp,
  output logic                errFlag
);
  dp_ctrl_t ctrl;
  logic     bufFull, bufEmpty;

  pwb_control u_control (
    .clk, .rstN, .reqValid, .reqWrite, .reqBurst, .reqLine, .reqSpace,
    .pciRespValid, .pciResp, .bufFull, .bufEmpty,
    .slvWait, .slvComplete, .slvRearb, .slvMErr, .pciReq, .errFlag, .ctrl
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_datapath (
    .clk, .rstN, .ctrl,
    .inAddr(reqAddr), .inData(reqData), .inBe(reqBe), .inSpace(reqSpace),
    .bufFull, .bufEmpty,
    .outAddr(pciAddr), .outData(pciData), .outBe(pciBe), .outSpace(pciSpace)
  );
endmodule

// File: tb/test_pci_write_bridge.sv
module test_pci_write_bridge;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqBurst = 0, reqLine = 0;
  logic [1:0] reqSpace = 0;
  logic [31:0] reqAddr = 0, reqData = 0;
  logic [3:0] reqBe = 0;
  logic slvWait, slvComplete, slvRearb, slvMErr, pciReq, errFlag;
  logic [31:0] pciAddr, pciData;
  logic [3:0] pciBe;
  logic [1:0] pciSpace;
  logic pciRespValid = 0;
  logic [2:0] pciResp = 0;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  pci_write_bridge i_pci_write_bridge (.*);

  typedef struct packed {
    logic wr, bu, ln; logic [1:0] sp; logic [2:0] rsp;
    logic c0, w0, pr, c1, rb, me, er, bo; logic [3:0] rq;
  } vec_t;

  // wr bu ln sp rsp | c0 w0 pr c1 rb me er bo | req
  localparam vec_t VECS [14] = '{
    '{1,0,0,0,0, 1,0,1,0,0,0,0,0, 2},   // R2 R3 memory, accept
    '{1,0,0,1,3, 1,0,1,0,0,0,1,0, 11},  // R11 I/O, master abort
    '{1,0,0,0,4, 1,0,1,0,0,0,1,0, 11},  // R11 memory, target abort
    '{1,0,0,0,1, 1,0,1,0,0,0,0,1, 4},   // R4 memory, retry
    '{1,0,0,1,2, 1,0,1,0,0,0,0,1, 4},   // R4 I/O, disconnect
    '{1,0,0,2,0, 0,1,1,1,0,0,0,0, 7},   // R7 config, accept
    '{1,0,0,3,2, 0,1,1,1,0,0,0,0, 7},   // R7 special, disconnect
    '{1,0,0,2,1, 0,1,1,0,1,0,0,0, 6},   // R6 config, retry
    '{1,0,0,2,3, 0,1,1,1,0,1,0,0, 8},   // R8 config, master abort
    '{1,0,0,3,4, 0,1,1,1,0,1,0,0, 8},   // R8 special, target abort
    '{1,1,0,0,0, 0,0,0,0,0,0,0,0, 1},   // R1 burst write
    '{1,0,1,2,0, 0,0,0,0,0,0,0,0, 1},   // R1 line write
    '{0,0,0,0,0, 0,0,0,0,0,0,0,0, 1},   // R1 single read
    '{0,1,0,1,0, 0,0,0,0,0,0,0,0, 1}    // R1 burst read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    reqValid = 0; reqWrite = 0; reqBurst = 0; reqLine = 0; reqSpace = 0;
    pciRespValid = 0; pciResp = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; quiet();
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic present(input logic [1:0] sp, input logic [31:0] a);
    reqValid = 1; reqWrite = 1; reqBurst = 0; reqLine = 0;
    reqSpace = sp; reqAddr = a; reqData = ~a; reqBe = 4'hF;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R12 reset state
    rstN = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R12 outputs in reset", {slvWait, slvComplete, slvRearb, slvMErr, pciReq, errFlag}, 0);
    @(negedge clk); rstN = 1;
    @(negedge clk); #1;
    chk("R12 outputs after reset", {slvWait, slvComplete, slvRearb, slvMErr, pciReq, errFlag}, 0);

    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic string t = $sformatf("R%0d vec%0d", v.rq, i);
      doReset();
      reqValid = 1; reqWrite = v.wr; reqBurst = v.bu; reqLine = v.ln;
      reqSpace = v.sp; reqAddr = 32'h1000 + i * 16; reqData = 32'hA5000000 + i; reqBe = 4'hF;
      #1;
      chk({t, " complete@req"}, slvComplete, v.c0);
      chk({t, " wait@req"}, slvWait, v.w0);
      @(negedge clk);
      if (!v.w0) reqValid = 0;
      #1;
      chk({t, " pciReq"}, pciReq, v.pr);
      if (v.pr) begin
        chk({t, " pciAddr"}, pciAddr, 32'h1000 + i * 16);
        pciRespValid = 1; pciResp = v.rsp;
      end
      #1;
      chk({t, " complete@resp"}, slvComplete, v.c1);
      chk({t, " rearb"}, slvRearb, v.rb);
      chk({t, " merr"}, slvMErr, v.me);
      @(negedge clk);
      quiet(); #1;
      chk({t, " errFlag"}, errFlag, v.er);
      chk({t, " pciReq gap"}, pciReq, 0);
      chk({t, " no wait after"}, slvWait, 0);
      @(negedge clk); #1;
      chk({t, " pciReq again"}, pciReq, v.bo);
    end

    // R9 R10 full buffer, pop and push in one cycle, arrival order
    doReset();
    present(0, 32'hA0); #1;
    chk("R2 first post", slvComplete, 1);
    @(negedge clk); present(1, 32'hB0); #1;
    chk("R2 second post", slvComplete, 1);
    chk("R10 head is first", pciAddr, 32'hA0);
    @(negedge clk); present(0, 32'hC0); #1;
    chk("R9 full wait", slvWait, 1);
    chk("R9 full no complete", slvComplete, 0);
    @(negedge clk); pciRespValid = 1; pciResp = 0; #1;
    chk("R9 complete with pop", slvComplete, 1);
    chk("R9 wait released", slvWait, 0);
    @(negedge clk); quiet(); #1;
    chk("R10 second out", pciAddr, 32'hB0);
    chk("R10 second space", pciSpace, 1);
    pciRespValid = 1;
    @(negedge clk); #1;
    chk("R10 third out", pciAddr, 32'hC0);
    chk("R10 third data", pciData, ~32'hC0);
    @(negedge clk); quiet(); #1;
    chk("R3 drained", pciReq, 0);

    // R5 held write waits behind posted write
    doReset();
    present(0, 32'h50); @(negedge clk);
    present(2, 32'h60); #1;
    chk("R5 cfg wait", slvWait, 1);
    chk("R5 posted first", pciAddr, 32'h50);
    pciRespValid = 1; pciResp = 0; #1;
    chk("R5 no complete for cfg yet", slvComplete, 0);
    @(negedge clk); pciRespValid = 0; #1;
    chk("R5 cfg issued", pciAddr, 32'h60);
    chk("R5 cfg space", pciSpace, 2);
    chk("R5 still waiting", slvWait, 1);
    pciRespValid = 1; pciResp = 0; #1;
    chk("R7 cfg completes", slvComplete, 1);
    @(negedge clk); quiet(); #1;
    chk("R7 idle after", pciReq, 0);

    // R4 same entry after retry, processor bus untouched
    doReset();
    present(0, 32'h70); @(negedge clk);
    reqValid = 0; pciRespValid = 1; pciResp = 1;
    @(negedge clk); quiet(); #1;
    chk("R4 gap", pciReq, 0);
    chk("R4 no processor action", {slvWait, slvComplete, slvRearb, slvMErr}, 0);
    @(negedge clk); #1;
    chk("R4 re-request", pciReq, 1);
    chk("R4 same entry", pciAddr, 32'h70);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule